// File: doc/BRIEF.md
# Mixed-Sensitivity Interrupt Pending Controller

This block gathers sixteen interrupt sources into one 32-bit pending word and raises a single request toward the processor core. Eight sources are external pins, which are active low. The other eight are internal level requests, which are active high. External and internal sources sit side by side in the word. Each external pin can be set to follow its input level or to latch on a falling edge. A latched edge stays pending until software clears it by writing a 1.

A mask register selects which pending bits may raise the output. A sensitivity register sets the mode of each external pin. The pending, mask and sensitivity registers are all reached through a small register bus. Writes are synchronous and reads are combinational. Besides the request line, the block reports the number of the highest-priority pending, unmasked source. The core uses that number to select a handler.

Bit numbering in every register word counts from the most significant end: word bit k is data bit 31-k.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After a synchronous reset, the mask and sensitivity registers read 0, so every pin is in level mode. With all pins high and all internal requests low, the pending word also reads 0.
- R2: In the pending word, bit 2n (data bit 31-2n) is external pin n and bit 2n+1 (data bit 30-2n) is internal request n. Addresses are: 0 pending, 1 mask, 2 sensitivity, 3 reads 0.
- R3: Data bits 15..0 of every register read 0, and writes to them are ignored.
- R4: An internal request bit shows in the pending word in the same cycle its input is high, and it leaves when the input drops.
- R5: A pin in level mode (sensitivity bit 0) reads pending as the inverse of the pin two clock edges after the pin changes.
- R6: A pin in edge mode (sensitivity bit 1, at data bit 31-2n) sets its pending bit on a falling edge. The bit becomes visible three clock edges after the pin falls and stays set while the pin returns high.
- R7: Writing 1 to an edge-mode pending bit clears it. Writing 0 has no effect, and writes to level-type pending bits have no effect.
- R8: If a new falling edge is detected in the same cycle as a clearing write to that bit, the bit stays set.
- R9: irq_o is high exactly when some pending bit has its mask bit set. The mask bit for word bit k is at data bit 31-k.
- R10: irq_idx gives the lowest-numbered word bit that is pending and unmasked, so bit 0 has the highest priority. It is 0 when irq_o is low.
- R11: The mask and sensitivity registers read back what was written, in their implemented bits. Leaving edge mode drops any latched edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_n | input | 8 | External request pins, active low |
| int_lvl | input | 8 | Internal level requests, active high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| irq_idx | output | 5 | Number of the highest-priority pending, unmasked source |

## Verification
The hardest case to reach is a falling edge being detected in exactly the cycle that a clearing write hits the same bit. The synchronizer hides the detection cycle, so the stimulus counts it from the pin. The bench first latches an edge and then lets the pin settle high. It then drives the pin low and issues the write-1 on the third clock edge after the fall. A cycle-accurate model in the bench tracks the pin history and mode changes. It compares the request line, the index and the read data on every clock, so mode switches in the middle of a latched edge are covered as well.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int NUM_PINS = 8;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = 5;

    typedef enum logic [1:0] {
        REG_PEND  = 2'd0,
        REG_MASK  = 2'd1,
        REG_SENSE = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    typedef struct packed {
        logic wr_pend;
        logic wr_mask;
        logic wr_sense;
    } bus_wr_t;

    // word bit k (counted from the MSB) to data index
    function automatic int unsigned word_pos(int unsigned width, int unsigned k);
        return width - 1 - k;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] level_req,
    output logic [N-1:0] fall
);
    for (genvar n = 0; n < N; n++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= pin_n[n];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level_req[n] = ~s2;
        assign fall[n]      = s3 & ~s2;
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] clr,
    output logic [N-1:0] latched
);
    import irq_pend_pkg::*;

    for (genvar n = 0; n < N; n++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)
                latched[n] <= 1'b0;
            else if (sense_e'(sense[n]) == SENSE_LEVEL)
                latched[n] <= 1'b0;
            else if (fall[n])
                latched[n] <= 1'b1;   // new edge beats a clear
            else if (clr[n])
                latched[n] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W     = 16,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (req[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
    parameter int NUM_PINS = irq_pend_pkg::NUM_PINS,
    parameter int WORD_W   = irq_pend_pkg::WORD_W,
    parameter int IDX_W    = irq_pend_pkg::IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] ext_irq_n,
    input  logic [NUM_PINS-1:0] int_lvl,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq_o,
    output logic [IDX_W-1:0]    irq_idx
);
    import irq_pend_pkg::*;

    localparam int SRC_W = 2 * NUM_PINS;

    bus_wr_t             wr;
    logic [NUM_PINS-1:0] level_req, fall, latched, clr, sense_q, ext_pend;
    logic [SRC_W-1:0]    mask_q, src_vec, armed;
    logic [WORD_W-1:0]   pend_word, mask_word, sense_word;

    always_comb begin
        wr.wr_pend  = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_PEND);
        wr.wr_mask  = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_MASK);
        wr.wr_sense = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_SENSE);
    end

    irq_pin_sync #(.N(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_n(ext_irq_n),
        .level_req(level_req), .fall(fall)
    );

    irq_edge_latch #(.N(NUM_PINS)) u_latch (
        .clk(clk), .rst(rst), .sense(sense_q), .fall(fall),
        .clr(clr), .latched(latched)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_src
        localparam int EXT_BIT = 2 * n;
        localparam int INT_BIT = 2 * n + 1;
        assign clr[n]           = wr.wr_pend && bus_wdata[WORD_W-1-EXT_BIT];
        assign ext_pend[n]      = sense_q[n] ? latched[n] : level_req[n];
        assign src_vec[EXT_BIT] = ext_pend[n];
        assign src_vec[INT_BIT] = int_lvl[n];

        always_ff @(posedge clk) begin
            if (rst)
                sense_q[n] <= 1'b0;
            else if (wr.wr_sense)
                sense_q[n] <= bus_wdata[WORD_W-1-EXT_BIT];
        end
    end

    for (genvar k = 0; k < SRC_W; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[k] <= 1'b0;
            else if (wr.wr_mask)
                mask_q[k] <= bus_wdata[WORD_W-1-k];
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_word
        if (b < SRC_W) begin : g_live
            assign pend_word[WORD_W-1-b] = src_vec[b];
            assign mask_word[WORD_W-1-b] = mask_q[b];
            if (b % 2 == 0) begin : g_ext
                assign sense_word[WORD_W-1-b] = sense_q[b/2];
            end else begin : g_int
                assign sense_word[WORD_W-1-b] = 1'b0;
            end
        end else begin : g_rsvd
            assign pend_word[WORD_W-1-b]  = 1'b0;
            assign mask_word[WORD_W-1-b]  = 1'b0;
            assign sense_word[WORD_W-1-b] = 1'b0;
        end
    end

    assign armed = src_vec & mask_q;

    irq_prio_enc #(.W(SRC_W), .IDX_W(IDX_W)) u_prio (
        .req(armed), .any(irq_o), .idx(irq_idx)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_PEND:  bus_rdata = pend_word;
            REG_MASK:  bus_rdata = mask_word;
            REG_SENSE: bus_rdata = sense_word;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
    parameter int NUM_PINS = 8,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_PINS-1:0]   ext_irq_n,
    input logic [NUM_PINS-1:0]   int_lvl,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [1:0]            bus_addr,
    input logic [WORD_W-1:0]     bus_rdata,
    input logic                  irq_o,
    input logic [IDX_W-1:0]      irq_idx,
    input logic [NUM_PINS-1:0]   sense_q,
    input logic [NUM_PINS-1:0]   ext_pend,
    input logic [NUM_PINS-1:0]   clr,
    input logic [2*NUM_PINS-1:0] src_vec,
    input logic [2*NUM_PINS-1:0] mask_q
);
    localparam int SRC_W = 2 * NUM_PINS;

    logic [1:0]       cyc;
    logic [SRC_W-1:0] armed, below;
    logic             sense_wr;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assign armed    = src_vec & mask_q;
    assign below    = (SRC_W'(1) << irq_idx) - SRC_W'(1);
    assign sense_wr = bus_sel && bus_wr && (bus_addr == 2'd2);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[WORD_W-SRC_W-1:0] == '0);

    assert_any_raises_R9: assert property (@(posedge clk) disable iff (rst)
        (armed != '0) |-> irq_o);

    assert_idx_valid_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> armed[irq_idx]);

    assert_idx_lowest_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((armed & below) == '0));

    assert_idx_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (irq_idx == '0));

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assert_int_track_R4: assert property (@(posedge clk) disable iff (rst)
            (bus_addr == 2'd0) |-> (bus_rdata[WORD_W-2-2*n] == int_lvl[n]));

        assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
            (cyc == 2'd3 && !sense_q[n]) |-> (ext_pend[n] == !$past(ext_irq_n[n], 2)));

        assert_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (sense_q[n] && ext_pend[n] && !clr[n] && !sense_wr) |=> ext_pend[n]);
    end
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
    .NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .int_lvl(int_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_idx(irq_idx),
    .sense_q(sense_q), .ext_pend(ext_pend), .clr(clr),
    .src_vec(src_vec), .mask_q(mask_q)
);

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ext_irq_n = 8'hFF;
    logic [7:0]  int_lvl = 8'h00;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [4:0]  irq_idx;

    integer checks = 0;
    integer errors = 0;
    bit     done = 0;
    string  cur_req = "R1";

    // behavioural model state
    bit [7:0]  m_h1 = 8'hFF, m_h2 = 8'hFF, m_h3 = 8'hFF;
    bit [7:0]  m_lat = 0, m_sense = 0;
    bit [15:0] m_mask = 0;

    always #5 clk = ~clk;

    irq_pend_ctrl uut (
        .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .int_lvl(int_lvl),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .irq_idx(irq_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_pend();
        bit [31:0] w = 0;
        for (int n = 0; n < 8; n++) begin
            w[31-2*n] = m_sense[n] ? m_lat[n] : ~m_h2[n];
            w[30-2*n] = int_lvl[n];
        end
        return w;
    endfunction

    function automatic bit [31:0] m_read();
        bit [31:0] w = 0;
        case (bus_addr)
            2'd0: w = m_pend();
            2'd1: for (int k = 0; k < 16; k++) w[31-k] = m_mask[k];
            2'd2: for (int n = 0; n < 8; n++) w[31-2*n] = m_sense[n];
            default: w = 0;
        endcase
        return w;
    endfunction

    // compare, advance one clock, update the model; starts and ends at a negedge
    task automatic tick();
        bit [31:0] pw;
        bit        e_irq;
        int        e_idx;
        bit [7:0]  fall, clr, nlat;
        #1;
        pw = m_pend();
        e_irq = 0;
        e_idx = 0;
        for (int k = 15; k >= 0; k--)
            if (pw[31-k] && m_mask[k]) begin e_irq = 1; e_idx = k; end
        if (!rst) begin
            chk("R9", {31'd0, irq_o}, {31'd0, e_irq});
            chk("R10", {27'd0, irq_idx}, e_idx[31:0]);
            chk(cur_req, bus_rdata, m_read());
        end
        @(posedge clk);
        if (rst) begin
            m_h1 = 8'hFF; m_h2 = 8'hFF; m_h3 = 8'hFF;
            m_lat = 0; m_sense = 0; m_mask = 0;
        end else begin
            fall = m_h3 & ~m_h2;
            for (int n = 0; n < 8; n++)
                clr[n] = bus_sel && bus_wr && bus_addr == 2'd0 && bus_wdata[31-2*n];
            for (int n = 0; n < 8; n++) begin
                if (!m_sense[n]) nlat[n] = 0;
                else if (fall[n]) nlat[n] = 1;
                else if (clr[n]) nlat[n] = 0;
                else nlat[n] = m_lat[n];
            end
            m_lat = nlat;
            if (bus_sel && bus_wr && bus_addr == 2'd1)
                for (int k = 0; k < 16; k++) m_mask[k] = bus_wdata[31-k];
            if (bus_sel && bus_wr && bus_addr == 2'd2)
                for (int n = 0; n < 8; n++) m_sense[n] = bus_wdata[31-2*n];
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = ext_irq_n;
        end
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;

        // R1 reset state
        cur_req = "R1";
        rd_reg(2'd0); chk("R1", bus_rdata, 32'h0);
        rd_reg(2'd1); chk("R1", bus_rdata, 32'h0);
        rd_reg(2'd2); chk("R1", bus_rdata, 32'h0);
        chk("R1", {31'd0, irq_o}, 32'd0);

        // R11 / R3 register read-back with reserved bits
        cur_req = "R11";
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1); chk("R3", bus_rdata, 32'hFFFF_0000);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd2); chk("R11", bus_rdata, 32'hAAAA_0000);
        wr_reg(2'd2, 32'h0);
        rd_reg(2'd3); chk("R2", bus_rdata, 32'h0);

        // R4 internal level tracking
        cur_req = "R4";
        bus_addr = 2'd0;
        int_lvl = 8'h80; tick(); chk("R4", {27'd0, irq_idx}, 32'd15);
        int_lvl = 8'h01; tick(); chk("R4", {27'd0, irq_idx}, 32'd1);
        int_lvl = 8'h00; tick(); chk("R4", {31'd0, irq_o}, 32'd0);

        // R5 / R2 level-mode pin
        cur_req = "R5";
        ext_irq_n = 8'b1111_0111; tick(); tick();
        chk("R5", {27'd0, irq_idx}, 32'd6);
        int_lvl = 8'h01; tick();
        chk("R2", bus_rdata, 32'h4200_0000);
        chk("R10", {27'd0, irq_idx}, 32'd1);
        ext_irq_n = 8'hFF; int_lvl = 8'h0; idle(3);
        chk("R5", bus_rdata, 32'h0);

        // R9 masking
        cur_req = "R9";
        int_lvl = 8'h10; wr_reg(2'd1, 32'h0);
        chk("R9", {31'd0, irq_o}, 32'd0);
        wr_reg(2'd1, 32'h0080_0000);  // word bit 8 -> internal 4? bit 9 is internal 4
        chk("R9", {31'd0, irq_o}, 32'd0);
        wr_reg(2'd1, 32'h0040_0000);  // word bit 9 = internal 4
        chk("R9", {31'd0, irq_o}, 32'd1);
        chk("R10", {27'd0, irq_idx}, 32'd9);
        int_lvl = 8'h0;
        wr_reg(2'd1, 32'hFFFF_0000);

        // R6 edge capture
        cur_req = "R6";
        wr_reg(2'd2, 32'hFFFF_0000);
        bus_addr = 2'd0;
        ext_irq_n = 8'hFE; tick(); ext_irq_n = 8'hFF;
        tick();
        chk("R6", bus_rdata, 32'h0);
        tick();
        chk("R6", bus_rdata, 32'h8000_0000);
        idle(5);
        chk("R6", bus_rdata, 32'h8000_0000);
        chk("R10", {27'd0, irq_idx}, 32'd0);

        // R7 write-1-to-clear
        cur_req = "R7";
        int_lvl = 8'h01;
        wr_reg(2'd0, 32'h0);
        rd_reg(2'd0); chk("R7", bus_rdata, 32'hC000_0000);
        wr_reg(2'd0, 32'h4000_0000);
        rd_reg(2'd0); chk("R7", bus_rdata, 32'hC000_0000);
        wr_reg(2'd0, 32'h8000_0000);
        rd_reg(2'd0); chk("R7", bus_rdata, 32'h4000_0000);
        int_lvl = 8'h0;

        // R8 edge wins over clear (pin 2, data bit 27)
        cur_req = "R8";
        ext_irq_n = 8'hFB; tick(); ext_irq_n = 8'hFF; idle(4);
        rd_reg(2'd0); chk("R8", bus_rdata, 32'h0800_0000);
        ext_irq_n = 8'hFB; tick(); tick();
        wr_reg(2'd0, 32'h0800_0000);
        rd_reg(2'd0); chk("R8", bus_rdata, 32'h0800_0000);
        ext_irq_n = 8'hFF; idle(3);
        wr_reg(2'd0, 32'h0800_0000);
        rd_reg(2'd0); chk("R8", bus_rdata, 32'h0);

        // R10 priority among several, R11 leaving edge mode
        cur_req = "R10";
        ext_irq_n = 8'h7F; tick(); ext_irq_n = 8'hFF; idle(4);
        int_lvl = 8'h08; tick();
        chk("R10", {27'd0, irq_idx}, 32'd7);
        int_lvl = 8'h0; tick();
        chk("R10", {27'd0, irq_idx}, 32'd14);
        cur_req = "R11";
        wr_reg(2'd2, 32'h0);
        rd_reg(2'd0); chk("R11", bus_rdata, 32'h0);

        idle(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule